// File: doc/BRIEF.md
# Endpoint FIFO Access Command/Status Register

This block is the single command/status register a microcontroller uses to reach one of several endpoint FIFOs inside a USB device controller. Firmware writes one word to pick an endpoint, say which way data will move, and raise a request. It then watches a read-only ready bit for the selected FIFO. When the transfer is finished it drops the request in a fixed order. The register drives select, direction, request and flush lines toward the FIFO logic. It also issues a one-cycle completion strobe when the request falls.

The serial engine reports two events into the register: a SETUP packet has landed, and the host has sent a zero-length packet. Each event sets a sticky flag. Only hardware sets these flags and only firmware clears them, so an event is not lost while firmware is busy. A bus reset from the serial engine clears the whole register in one cycle.

Register word (default 8 bits): bit0 request, bit1 direction (1 = MCU writes the FIFO, 0 = MCU reads), bits3:2 endpoint select, bit4 flush command, bit5 SETUP flag, bit6 zero-length flag, bit7 ready.

Top module: `ep_access_ctl`

## Requirements
- R1: After rst_ni is asserted low, every output is 0 and rd_data_o reads 0 in all bits apart from the ready bit (bit7).
- R2: Select bits3:2 of a write choose the endpoint (00→FIFO0, 01→FIFO1, 10→FIFO2, 11→FIFO3). The value appears on sel_o the cycle after the write, and bit7 of rd_data_o then equals ready_i[sel_o].
- R3: Request bit0 and direction bit1 of a write appear on req_o and dir_o the cycle after the write, and read back at the same positions.
- R4: A write that takes req from 1 to 0 gives a one-cycle done_o pulse in the cycle after the write. With that pulse, done_dir_o carries the direction value held before the write. No write that leaves req at 0 pulses done_o.
- R5: Writing 1 to bit4 pulses clr_o for exactly one cycle after the write, whether or not the selected FIFO is ready. Bit4 always reads 0.
- R6: setup_evt_i sets the SETUP flag (bit5) in the next cycle. Writing 1 to bit5 leaves the flag unchanged, and writing 0 clears it.
- R7: zlp_evt_i sets the zero-length flag (bit6) with the same semantics as R6.
- R8: An event that arrives in the same cycle as a firmware write of 0 to its flag leaves the flag set.
- R9: bus_reset_i clears every register field, flag and strobe in the next cycle. It takes priority over writes and events in the same cycle.
- R10: Bit7 is read-only: a write never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Synchronous clear from the serial engine's bus reset |
| wr_en_i | input | 1 | Firmware register write strobe |
| wr_data_i | input | REG_W | Firmware write data |
| rd_data_o | output | REG_W | Register read value |
| ready_i | input | NUM_EP | Per-FIFO ready indications |
| setup_evt_i | input | 1 | SETUP packet received event |
| zlp_evt_i | input | 1 | Zero-length packet received event |
| sel_o | output | SEL_W | Selected endpoint FIFO |
| dir_o | output | 1 | Transfer direction, 1 = MCU writes FIFO |
| req_o | output | 1 | Access request |
| clr_o | output | 1 | One-cycle flush strobe for the selected FIFO |
| done_o | output | 1 | One-cycle completion strobe on request fall |
| done_dir_o | output | 1 | Direction held at the last completion |

## Verification
The bench builds the block with the default four endpoints, so the select field is two bits wide and the register is eight bits wide. All four select codes can then be tried against a ready vector with a single bit set. The write-then-read completion ordering can be run in both directions. The bench also drives flag events into the same cycle as firmware clears and bus resets, which exercises the priority order.

// File: rtl/ep_access_pkg.sv
package ep_access_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xfer_dir_e;

  localparam int FLAG_SETUP = 0;
  localparam int FLAG_ZLP   = 1;
  localparam int NUM_FLAGS  = 2;

  function automatic int sel_lo_pos();
    return 2;
  endfunction

  function automatic int clr_pos(input int sel_w);
    return sel_lo_pos() + sel_w;
  endfunction
endpackage

// File: rtl/ep_cmd_reg.sv
module ep_cmd_reg
  import ep_access_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             wr_en_i,
  input  logic             req_wr_i,
  input  logic             dir_wr_i,
  input  logic [SEL_W-1:0] sel_wr_i,
  input  logic             clr_wr_i,
  output logic             req_o,
  output logic             dir_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_o,
  output logic             done_o,
  output logic             done_dir_o
);
  logic             req_q, clr_q, done_q, done_dir_q;
  xfer_dir_e        dir_q;
  logic [SEL_W-1:0] sel_q;
  logic             req_fall;

  assign req_fall = wr_en_i && req_q && !req_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      dir_q      <= DIR_RD;
      sel_q      <= '0;
      clr_q      <= 1'b0;
      done_q     <= 1'b0;
      done_dir_q <= 1'b0;
    end else if (bus_reset_i) begin
      req_q      <= 1'b0;
      dir_q      <= DIR_RD;
      sel_q      <= '0;
      clr_q      <= 1'b0;
      done_q     <= 1'b0;
      done_dir_q <= 1'b0;
    end else begin
      clr_q  <= wr_en_i && clr_wr_i;
      done_q <= req_fall;
      // direction held before the dropping write
      if (req_fall) done_dir_q <= dir_q;
      if (wr_en_i) begin
        req_q <= req_wr_i;
        dir_q <= xfer_dir_e'(dir_wr_i);
        sel_q <= sel_wr_i;
      end
    end
  end

  assign req_o      = req_q;
  assign dir_o      = dir_q;
  assign sel_o      = sel_q;
  assign clr_o      = clr_q;
  assign done_o     = done_q;
  assign done_dir_o = done_dir_q;
endmodule

// File: rtl/ep_sticky_flag.sv
module ep_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_reset_i,
  input  logic set_i,
  input  logic fw_clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (bus_reset_i) flag_q <= 1'b0;
    else if (set_i)       flag_q <= 1'b1;  // hardware set wins over firmware clear
    else if (fw_clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ep_ready_mux.sv
module ep_ready_mux #(
  parameter int NUM_EP = 4,
  localparam int SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic [NUM_EP-1:0] ready_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              ready_o
);
  always_comb begin
    ready_o = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel_i == SEL_W'(i)) ready_o = ready_i[i];
    end
  end
endmodule

// File: rtl/ep_access_ctl.sv
module ep_access_ctl
  import ep_access_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int SEL_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int SEL_LO  = sel_lo_pos(),
  localparam int CLR_B   = clr_pos(SEL_W),
  localparam int SETUP_B = CLR_B + 1,
  localparam int ZLP_B   = CLR_B + 2,
  localparam int RDY_B   = CLR_B + 3,
  localparam int REG_W   = RDY_B + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [NUM_EP-1:0] ready_i,
  input  logic              setup_evt_i,
  input  logic              zlp_evt_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              dir_o,
  output logic              req_o,
  output logic              clr_o,
  output logic              done_o,
  output logic              done_dir_o
);
  localparam int REQ_B = 0;
  localparam int DIR_B = 1;

  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;
  logic                 ready_sel;

  ep_cmd_reg #(.SEL_W(SEL_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_reset_i (bus_reset_i),
    .wr_en_i     (wr_en_i),
    .req_wr_i    (wr_data_i[REQ_B]),
    .dir_wr_i    (wr_data_i[DIR_B]),
    .sel_wr_i    (wr_data_i[SEL_LO +: SEL_W]),
    .clr_wr_i    (wr_data_i[CLR_B]),
    .req_o       (req_o),
    .dir_o       (dir_o),
    .sel_o       (sel_o),
    .clr_o       (clr_o),
    .done_o      (done_o),
    .done_dir_o  (done_dir_o)
  );

  assign flag_set[FLAG_SETUP] = setup_evt_i;
  assign flag_set[FLAG_ZLP]   = zlp_evt_i;
  assign flag_clr[FLAG_SETUP] = wr_en_i && !wr_data_i[SETUP_B];
  assign flag_clr[FLAG_ZLP]   = wr_en_i && !wr_data_i[ZLP_B];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    ep_sticky_flag u_flag (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bus_reset_i (bus_reset_i),
      .set_i       (flag_set[g]),
      .fw_clr_i    (flag_clr[g]),
      .flag_o      (flag_q[g])
    );
  end

  ep_ready_mux #(.NUM_EP(NUM_EP)) u_rdy (
    .ready_i (ready_i),
    .sel_i   (sel_o),
    .ready_o (ready_sel)
  );

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[REQ_B]              = req_o;
    rd_data_o[DIR_B]              = dir_o;
    rd_data_o[SEL_LO +: SEL_W]    = sel_o;
    rd_data_o[SETUP_B]            = flag_q[FLAG_SETUP];
    rd_data_o[ZLP_B]              = flag_q[FLAG_ZLP];
    rd_data_o[RDY_B]              = ready_sel;
  end
endmodule

// File: rtl/ep_access_chk.sv
module ep_access_chk #(
  parameter int NUM_EP = 4,
  localparam int SEL_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CLR_B   = 2 + SEL_W,
  localparam int SETUP_B = CLR_B + 1,
  localparam int ZLP_B   = CLR_B + 2,
  localparam int RDY_B   = CLR_B + 3,
  localparam int REG_W   = RDY_B + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_reset_i,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              setup_evt_i,
  input logic              zlp_evt_i,
  input logic              req_o,
  input logic              dir_o,
  input logic              clr_o,
  input logic              done_o,
  input logic              done_dir_o
);
  // R4
  done_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_o && $past(req_o)));
  // R4
  done_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_dir_o == $past(dir_o)));
  // R5
  clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(wr_en_i && wr_data_i[CLR_B] && !bus_reset_i));
  // R6 R8
  setup_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_evt_i && !bus_reset_i) |=> rd_data_o[SETUP_B]);
  // R7 R8
  zlp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zlp_evt_i && !bus_reset_i) |=> rd_data_o[ZLP_B]);
  // R6
  setup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[SETUP_B] && !bus_reset_i && !(wr_en_i && !wr_data_i[SETUP_B]))
      |=> rd_data_o[SETUP_B]);
  // R9
  bus_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (rd_data_o[RDY_B-1:0] == '0 && !clr_o && !done_o && !done_dir_o));
  // R5
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[CLR_B]);
endmodule

bind ep_access_ctl ep_access_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_reset_i (bus_reset_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .setup_evt_i (setup_evt_i),
  .zlp_evt_i   (zlp_evt_i),
  .req_o       (req_o),
  .dir_o       (dir_o),
  .clr_o       (clr_o),
  .done_o      (done_o),
  .done_dir_o  (done_dir_o)
);

// File: tb/ep_access_ctl_bench.sv
module ep_access_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;

  typedef enum int {K_RD, K_SEL, K_REQ, K_DIR, K_CLR, K_DONE, K_DDIR} kind_e;
  typedef struct {
    kind_e       kind;
    logic [7:0]  val;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [3:0] ready = '0;
  logic       setup_evt = 1'b0, zlp_evt = 1'b0;
  logic [1:0] sel;
  logic       dir, req, clr, done, done_dir;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  bit   finished = 0;

  // bench model
  logic       m_req = 0, m_dir = 0, m_setup = 0, m_zlp = 0, m_clr = 0, m_done = 0, m_ddir = 0;
  logic [1:0] m_sel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_access_ctl #(.NUM_EP(NUM_EP)) u_ep_access_ctl (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_rst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .ready_i(ready), .setup_evt_i(setup_evt), .zlp_evt_i(zlp_evt),
    .sel_o(sel), .dir_o(dir), .req_o(req), .clr_o(clr),
    .done_o(done), .done_dir_o(done_dir)
  );

  function automatic logic [7:0] actual(kind_e k);
    case (k)
      K_RD:    return rd_data;
      K_SEL:   return {6'b0, sel};
      K_REQ:   return {7'b0, req};
      K_DIR:   return {7'b0, dir};
      K_CLR:   return {7'b0, clr};
      K_DONE:  return {7'b0, done};
      default: return {7'b0, done_dir};
    endcase
  endfunction

  // monitor: compare at negedge, state settled from the previous posedge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [7:0] a;
      e = q.pop_front();
      a = actual(e.kind);
      n_cmp++;
      if (a !== e.val) begin
        n_bad++;
        $display("FAIL %s kind=%s actual=%h expected=%h", e.tag, e.kind.name(), a, e.val);
      end
    end
  end

  task automatic push_all(string tag);
    q.push_back('{K_RD,   {ready[m_sel], m_zlp, m_setup, 1'b0, m_sel, m_dir, m_req}, tag});
    q.push_back('{K_SEL,  {6'b0, m_sel}, tag});
    q.push_back('{K_REQ,  {7'b0, m_req}, tag});
    q.push_back('{K_DIR,  {7'b0, m_dir}, tag});
    q.push_back('{K_CLR,  {7'b0, m_clr}, tag});
    q.push_back('{K_DONE, {7'b0, m_done}, tag});
    q.push_back('{K_DDIR, {7'b0, m_ddir}, tag});
  endtask

  // one cycle of stimulus with model update from the requirements
  task automatic step(string tag, logic we, logic [7:0] d, logic se, logic ze, logic br);
    @(negedge clk); #1;
    wr_en = we; wr_data = d; setup_evt = se; zlp_evt = ze; bus_rst = br;
    if (br) begin
      m_req = 0; m_dir = 0; m_sel = 0; m_setup = 0; m_zlp = 0;
      m_clr = 0; m_done = 0; m_ddir = 0;
    end else begin
      m_done = we && m_req && !d[0];
      if (m_done) m_ddir = m_dir;
      m_clr = we && d[4];
      if (we) begin
        m_req = d[0]; m_dir = d[1]; m_sel = d[3:2];
        m_setup = m_setup & d[5];
        m_zlp   = m_zlp & d[6];
      end
      m_setup = m_setup | se;
      m_zlp   = m_zlp | ze;
    end
    @(posedge clk); #1;
    push_all(tag);
    @(negedge clk); #1;
    wr_en = 0; setup_evt = 0; zlp_evt = 0; bus_rst = 0;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 8'h00, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ready = 4'b0100;
    repeat (3) @(negedge clk);
    push_all("R1 reset");
    @(negedge clk); #1;
    rst_n = 1;
    idle("R1 idle after reset");

    // R2: walk all select codes against a one-hot ready vector
    for (int i = 0; i < 4; i++) step("R2 select", 1, {4'b0, 2'(i), 2'b00}, 0, 0, 0);
    ready = 4'b0001;
    idle("R2 ready tracks");

    // R3 + R4: write transfer, dir cleared before request drop
    step("R3 write req", 1, 8'b0000_0111, 0, 0, 0);
    step("R3 dir clear", 1, 8'b0000_0101, 0, 0, 0);
    step("R4 write done", 1, 8'b0000_0100, 0, 0, 0);
    idle("R4 done is one cycle");
    step("R4 no pulse when req stays 0", 1, 8'b0000_0000, 0, 0, 0);

    // R4: read transfer, dir set after the job
    step("R3 read req", 1, 8'b0000_1001, 0, 0, 0);
    step("R3 read dir set", 1, 8'b0000_1011, 0, 0, 0);
    step("R4 read done", 1, 8'b0000_1010, 0, 0, 0);

    // R5: flush with selected FIFO not ready
    ready = 4'b0000;
    step("R5 clr not ready", 1, 8'b0001_1100, 0, 0, 0);
    idle("R5 clr one cycle");

    // R6 / R7 / R8
    step("R6 setup set", 0, 8'h00, 1, 0, 0);
    step("R6 write 1 keeps", 1, 8'b0010_0000, 0, 0, 0);
    step("R6 write 0 clears", 1, 8'b0000_0000, 0, 0, 0);
    step("R7 zlp set", 0, 8'h00, 0, 1, 0);
    step("R7 write 1 keeps", 1, 8'b0100_0000, 0, 0, 0);
    step("R7 write 0 clears", 1, 8'b0000_0000, 0, 0, 0);
    step("R8 setup set vs clear", 1, 8'b0000_0000, 1, 0, 0);
    step("R8 zlp set vs clear", 1, 8'b0010_0000, 0, 1, 0);

    // R10: write ready bit, ready input low
    ready = 4'b0000;
    step("R10 ready read only", 1, 8'b1110_0001, 0, 0, 0);
    ready = 4'b0001;
    idle("R10 ready from input");

    // R9: bus reset beats write and events
    step("R9 bus reset priority", 1, 8'b0111_1111, 1, 1, 1);
    idle("R9 cleared");
    step("R9 arm", 1, 8'b0000_0011, 0, 0, 0);
    step("R9 reset drops req no done", 0, 8'h00, 0, 0, 1);

    idle("final");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule